// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block judges one access against one TLB entry that has already matched the virtual address. The entry holds two page descriptors, one for the even page and one for the odd page of an aligned pair. One virtual-address bit, at the current page-size shift, picks between them. The chosen descriptor then goes through a fixed chain of access checks, and the block forms the physical address and the read, write and execute permissions.

A separate flag tells the caller to have the page-table walker set the dirty bit. It is raised when hardware dirty-setting is on and a store hits a writable but clean page. All results are registered and appear one cycle after a request. The entry search, the table walk and exception delivery are done elsewhere.

Top module: `tlb_perm_check`

## Requirements
- R1: A descriptor is DESC_W = PA_W-4 bits wide. Bit 0 is valid, bit 1 is dirty, bit 2 is writable, bits 4:3 are the page privilege, bit 5 is no-execute, bit 6 is no-read, bit 7 is restricted-privilege, and bits DESC_W-1:8 are the frame number (physical address bits PA_W-1:12). Bit vaddr_i[page_shift_i] picks desc_odd_i when 1 and desc_even_i when 0.
- R2: A page_shift_i below 12 or above 30 gives result INVALID (code 1), whatever else is applied.
- R3: When hw_dirty_en_i is 1, access_i is store (2), and the chosen descriptor has writable=1 and dirty=0, the result is SET_D (code 6). This holds even when the page is not valid, and set_dirty_o is 1 exactly when the result is SET_D.
- R4: Otherwise the first failing check sets the result, in this order: valid=0 gives INVALID (1); fetch (access code 0) with no-execute gives XI (2); load (code 1, and code 3 is also treated as a load) with no-read gives RI (3); a privilege fault gives PE (4); a store with dirty=0 gives DIRTY (5). If no check fails, the result is MATCH (0).
- R5: With restricted-privilege 0, a privilege fault occurs when cur_plv_i is greater than the page privilege. With restricted-privilege 1, it occurs whenever the two differ.
- R6: When mode64_i is 0, the no-execute, no-read and restricted-privilege bits are taken as 0.
- R7: On MATCH, paddr_o is the frame number placed at bit 12 with bits 12 to page_shift_i-1 cleared, OR'd with vaddr bits page_shift_i-1:0.
- R8: On MATCH, perm_r_o is 1, perm_w_o equals dirty, and perm_x_o is the inverse of the effective no-execute bit. On any other result, paddr_o and all three permissions are 0.
- R9: Outputs update on the clock edge after req_valid_i is 1 and hold otherwise. rsp_valid_o is req_valid_i delayed by one cycle. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| vaddr_i | input | VA_W | Virtual address |
| access_i | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| cur_plv_i | input | 2 | Current privilege level |
| page_shift_i | input | 5 | Page size as log2 of bytes |
| mode64_i | input | 1 | 1 for 64-bit descriptor fields |
| hw_dirty_en_i | input | 1 | Enable hardware dirty-setting |
| desc_even_i | input | DESC_W | Even page descriptor |
| desc_odd_i | input | DESC_W | Odd page descriptor |
| rsp_valid_o | output | 1 | Response strobe |
| result_o | output | 3 | Result code |
| paddr_o | output | PA_W | Physical address |
| perm_r_o | output | 1 | Read allowed |
| perm_w_o | output | 1 | Write allowed |
| perm_x_o | output | 1 | Execute allowed |
| set_dirty_o | output | 1 | Walker must set the dirty bit |

## Verification
The bench builds entries in which several faults are present together. A chain checked in the wrong order then returns the wrong code, for example XI where INVALID is due, or a late SET_D. It sweeps page shifts across the 12 and 30 limits and sets the vaddr bit at page_shift_i both ways. An off-by-one odd/even selector, or an out-of-range shift that is accepted, then gives a wrong code or address. Frame numbers carry set software-owned bits, so an address formed without clearing them shows up as a wrong paddr_o. Further cases cover the two privilege modes, where an equality test and a magnitude test disagree, and 32-bit mode with set upper flags, where a design that leaves those flags active faults a legal access.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;
  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_XI      = 3'd2,
    RES_RI      = 3'd3,
    RES_PE      = 3'd4,
    RES_DIRTY   = 3'd5,
    RES_SET_D   = 3'd6
  } res_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned PS_MIN   = 12;
  localparam int unsigned PS_MAX   = 30;

  // bit order matches descriptor bits 7..0
  typedef struct packed {
    logic       rplv;
    logic       nr;
    logic       nx;
    logic [1:0] plv;
    logic       w;
    logic       d;
    logic       v;
  } desc_flags_t;
endpackage

// File: rtl/tlb_pair_select.sv
module tlb_pair_select
  import tlb_perm_pkg::*;
#(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned DESC_W = 44,
  localparam int unsigned PPN_W = DESC_W - FLAG_W
) (
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [4:0]        page_shift_i,
  input  logic              mode64_i,
  input  logic [DESC_W-1:0] desc_even_i,
  input  logic [DESC_W-1:0] desc_odd_i,
  output desc_flags_t       flags_o,
  output logic [PPN_W-1:0]  ppn_o
);
  logic              odd_sel;
  logic [DESC_W-1:0] chosen;
  desc_flags_t       raw;

  assign odd_sel = vaddr_i[page_shift_i];
  assign chosen  = odd_sel ? desc_odd_i : desc_even_i;
  assign raw     = desc_flags_t'(chosen[FLAG_W-1:0]);
  assign ppn_o   = chosen[DESC_W-1:FLAG_W];

  always_comb begin
    flags_o = raw;
    if (!mode64_i) begin
      flags_o.nx   = 1'b0;
      flags_o.nr   = 1'b0;
      flags_o.rplv = 1'b0;
    end
  end
endmodule

// File: rtl/tlb_fault_prio.sv
module tlb_fault_prio
  import tlb_perm_pkg::*;
(
  input  desc_flags_t flags_i,
  input  logic [1:0]  access_i,
  input  logic [1:0]  cur_plv_i,
  input  logic        ps_ok_i,
  input  logic        hw_dirty_en_i,
  output res_e        res_o
);
  logic is_fetch, is_store, is_load, plv_fault;

  assign is_fetch = (access_i == ACC_FETCH);
  assign is_store = (access_i == ACC_STORE);
  assign is_load  = !is_fetch && !is_store;

  always_comb begin
    if (flags_i.rplv) plv_fault = (cur_plv_i != flags_i.plv);
    else              plv_fault = (cur_plv_i >  flags_i.plv);
  end

  always_comb begin
    if (!ps_ok_i)                                           res_o = RES_INVALID;
    else if (hw_dirty_en_i && is_store && flags_i.w && !flags_i.d) res_o = RES_SET_D;
    else if (!flags_i.v)                                    res_o = RES_INVALID;
    else if (is_fetch && flags_i.nx)                        res_o = RES_XI;
    else if (is_load && flags_i.nr)                         res_o = RES_RI;
    else if (plv_fault)                                     res_o = RES_PE;
    else if (is_store && !flags_i.d)                        res_o = RES_DIRTY;
    else                                                    res_o = RES_MATCH;
  end
endmodule

// File: rtl/tlb_pa_form.sv
module tlb_pa_form #(
  parameter int unsigned PA_W  = 48,
  localparam int unsigned PPN_W = PA_W - 12
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [PA_W-1:0]  va_i,
  input  logic [4:0]       page_shift_i,
  output logic [PA_W-1:0]  paddr_o
);
  logic [PA_W-1:0] low_mask, frame;

  assign low_mask = (PA_W'(1) << page_shift_i) - PA_W'(1);
  assign frame    = {ppn_i, 12'h000};
  // software bits between 12 and the page shift are dropped
  assign paddr_o  = (frame & ~low_mask) | (va_i & low_mask);
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_perm_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 48,
  localparam int unsigned PPN_W  = PA_W - 12,
  localparam int unsigned DESC_W = PPN_W + FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [1:0]        access_i,
  input  logic [1:0]        cur_plv_i,
  input  logic [4:0]        page_shift_i,
  input  logic              mode64_i,
  input  logic              hw_dirty_en_i,
  input  logic [DESC_W-1:0] desc_even_i,
  input  logic [DESC_W-1:0] desc_odd_i,
  output logic              rsp_valid_o,
  output logic [2:0]        result_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic              set_dirty_o
);
  desc_flags_t      flags;
  logic [PPN_W-1:0] ppn;
  logic [PA_W-1:0]  pa_calc;
  res_e             res;
  logic             ps_ok, hit;

  assign ps_ok = (page_shift_i >= 5'(PS_MIN)) && (page_shift_i <= 5'(PS_MAX));

  tlb_pair_select #(.VA_W(VA_W), .DESC_W(DESC_W)) i_sel (
    .vaddr_i      (vaddr_i),
    .page_shift_i (page_shift_i),
    .mode64_i     (mode64_i),
    .desc_even_i  (desc_even_i),
    .desc_odd_i   (desc_odd_i),
    .flags_o      (flags),
    .ppn_o        (ppn)
  );

  tlb_fault_prio i_prio (
    .flags_i       (flags),
    .access_i      (access_i),
    .cur_plv_i     (cur_plv_i),
    .ps_ok_i       (ps_ok),
    .hw_dirty_en_i (hw_dirty_en_i),
    .res_o         (res)
  );

  tlb_pa_form #(.PA_W(PA_W)) i_pa (
    .ppn_i        (ppn),
    .va_i         (PA_W'(vaddr_i)),
    .page_shift_i (page_shift_i),
    .paddr_o      (pa_calc)
  );

  assign hit = (res == RES_MATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      result_o    <= '0;
      paddr_o     <= '0;
      perm_r_o    <= 1'b0;
      perm_w_o    <= 1'b0;
      perm_x_o    <= 1'b0;
      set_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        result_o    <= res;
        paddr_o     <= hit ? pa_calc : '0;
        perm_r_o    <= hit;
        perm_w_o    <= hit && flags.d;
        perm_x_o    <= hit && !flags.nx;
        set_dirty_o <= (res == RES_SET_D);
      end
    end
  end

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(result_o) && $stable(paddr_o)));
  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (page_shift_i < 5'd12 || page_shift_i > 5'd30))
      |=> result_o == 3'd1);
  p_setd_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ps_ok && hw_dirty_en_i && access_i == 2'd2 && flags.w && !flags.d)
      |=> (result_o == 3'd6 && set_dirty_o));
  p_flag_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_dirty_o == (result_o == 3'd6));
  p_match_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == 3'd0) |-> perm_r_o);
  p_fault_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != 3'd0) |-> (paddr_o == '0 && !perm_r_o && !perm_w_o && !perm_x_o));
  p_code_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o != 3'd7);
endmodule

// File: tb/test_tlb_perm_check.sv
module test_tlb_perm_check;
  localparam int VA_W = 48;
  localparam int PA_W = 48;
  localparam int PPN_W = PA_W - 12;
  localparam int DESC_W = PPN_W + 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [VA_W-1:0]   vaddr_i = '0;
  logic [1:0]        access_i = '0;
  logic [1:0]        cur_plv_i = '0;
  logic [4:0]        page_shift_i = 5'd12;
  logic              mode64_i = 1'b1;
  logic              hw_dirty_en_i = 1'b0;
  logic [DESC_W-1:0] desc_even_i = '0;
  logic [DESC_W-1:0] desc_odd_i = '0;
  logic              rsp_valid_o;
  logic [2:0]        result_o;
  logic [PA_W-1:0]   paddr_o;
  logic              perm_r_o, perm_w_o, perm_x_o, set_dirty_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  tlb_perm_check #(.VA_W(VA_W), .PA_W(PA_W)) i_tlb_perm_check (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .vaddr_i(vaddr_i),
    .access_i(access_i), .cur_plv_i(cur_plv_i), .page_shift_i(page_shift_i),
    .mode64_i(mode64_i), .hw_dirty_en_i(hw_dirty_en_i),
    .desc_even_i(desc_even_i), .desc_odd_i(desc_odd_i),
    .rsp_valid_o(rsp_valid_o), .result_o(result_o), .paddr_o(paddr_o),
    .perm_r_o(perm_r_o), .perm_w_o(perm_w_o), .perm_x_o(perm_x_o),
    .set_dirty_o(set_dirty_o)
  );

  function automatic logic [DESC_W-1:0] mk(input logic [PPN_W-1:0] ppn, input bit rplv,
      input bit nr, input bit nx, input logic [1:0] plv, input bit w, input bit d, input bit v);
    return {ppn, rplv, nr, nx, plv, w, d, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(output logic [2:0] res, output logic [PA_W-1:0] pa,
      output logic [2:0] rwx);
    logic [DESC_W-1:0] dsc;
    bit v, d, w, nx, nr, rp, pf, st, fe, ld;
    logic [1:0] pl;
    logic [PA_W-1:0] frame, mask;
    dsc = ((vaddr_i >> page_shift_i) & 1) != 0 ? desc_odd_i : desc_even_i;
    v = dsc[0]; d = dsc[1]; w = dsc[2]; pl = dsc[4:3];
    nx = mode64_i & dsc[5]; nr = mode64_i & dsc[6]; rp = mode64_i & dsc[7];
    fe = access_i == 2'd0; st = access_i == 2'd2; ld = !fe && !st;
    pf = rp ? (cur_plv_i != pl) : (cur_plv_i > pl);
    pa = '0; rwx = 3'b000;
    if (page_shift_i < 12 || page_shift_i > 30) res = 3'd1;
    else if (hw_dirty_en_i && st && w && !d) res = 3'd6;
    else if (!v) res = 3'd1;
    else if (fe && nx) res = 3'd2;
    else if (ld && nr) res = 3'd3;
    else if (pf) res = 3'd4;
    else if (st && !d) res = 3'd5;
    else res = 3'd0;
    if (res == 3'd0) begin
      frame = PA_W'(dsc[DESC_W-1:8]) << 12;
      mask = (PA_W'(1) << page_shift_i) - 1;
      pa = ((frame >> page_shift_i) << page_shift_i) | (PA_W'(vaddr_i) & mask);
      rwx = {1'b1, d, !nx};
    end
  endfunction

  task automatic run(input string req);
    logic [2:0] er; logic [PA_W-1:0] ep; logic [2:0] erwx;
    req_valid_i = 1'b1;
    model(er, ep, erwx);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(rsp_valid_o, {req, " R9 valid"}, 64'(rsp_valid_o), 1);
    chk(result_o == er, {req, " result"}, 64'(result_o), 64'(er));
    chk(paddr_o == ep, {req, " paddr"}, 64'(paddr_o), 64'(ep));
    chk({perm_r_o, perm_w_o, perm_x_o} == erwx, {req, " R8 perms"},
        64'({perm_r_o, perm_w_o, perm_x_o}), 64'(erwx));
    chk(set_dirty_o == (er == 3'd6), {req, " R3 flag"}, 64'(set_dirty_o), 64'(er == 3'd6));
  endtask

  task automatic setup(input logic [VA_W-1:0] va, input logic [1:0] acc, input logic [1:0] plv,
      input logic [4:0] ps, input bit m64, input bit hw);
    vaddr_i = va; access_i = acc; cur_plv_i = plv; page_shift_i = ps;
    mode64_i = m64; hw_dirty_en_i = hw;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] hold_res; logic [PA_W-1:0] hold_pa;
    repeat (3) @(negedge clk);
    chk(!rsp_valid_o && result_o == 0 && paddr_o == 0 && !perm_r_o, "R9 reset",
        64'({rsp_valid_o, result_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: odd/even select
    desc_even_i = mk(36'h12345, 0, 0, 0, 2'd3, 1, 1, 1);
    desc_odd_i  = mk(36'h54321, 0, 0, 0, 2'd3, 1, 1, 0);
    setup(48'h0000_0000_3ABC, 2'd1, 2'd0, 5'd14, 1, 0); run("R1 even");
    setup(48'h0000_0000_7ABC, 2'd1, 2'd0, 5'd14, 1, 0); run("R1 odd");
    // R2: range limits
    desc_odd_i = desc_even_i;
    setup(48'h1234_5678_9ABC, 2'd1, 2'd0, 5'd11, 1, 0); run("R2 ps11");
    setup(48'h1234_5678_9ABC, 2'd1, 2'd0, 5'd31, 1, 0); run("R2 ps31");
    setup(48'h1234_5678_9ABC, 2'd1, 2'd0, 5'd30, 1, 0); run("R2 ps30 R7");
    setup(48'h1234_5678_9ABC, 2'd1, 2'd0, 5'd12, 1, 0); run("R2 ps12 R7");
    // R3: set dirty ahead of invalid
    desc_even_i = mk(36'h1, 1, 1, 1, 2'd0, 1, 0, 0); desc_odd_i = desc_even_i;
    setup(48'h1000, 2'd2, 2'd3, 5'd12, 1, 1); run("R3 setd");
    setup(48'h1000, 2'd2, 2'd3, 5'd12, 1, 0); run("R3 off R4 invalid");
    // R4: ordering
    desc_even_i = mk(36'h2, 1, 1, 1, 2'd0, 0, 0, 1); desc_odd_i = desc_even_i;
    setup(48'h0, 2'd0, 2'd3, 5'd12, 1, 0); run("R4 xi");
    setup(48'h0, 2'd1, 2'd3, 5'd12, 1, 0); run("R4 ri");
    setup(48'h0, 2'd3, 2'd3, 5'd12, 1, 0); run("R4 ri code3");
    setup(48'h0, 2'd2, 2'd3, 5'd12, 1, 0); run("R4 pe");
    setup(48'h0, 2'd2, 2'd0, 5'd12, 1, 0); run("R4 dirty");
    // R5: privilege modes
    desc_even_i = mk(36'h3, 1, 0, 0, 2'd2, 1, 1, 1); desc_odd_i = desc_even_i;
    setup(48'h0, 2'd1, 2'd0, 5'd12, 1, 0); run("R5 exact lower");
    setup(48'h0, 2'd1, 2'd2, 5'd12, 1, 0); run("R5 exact equal");
    desc_even_i = mk(36'h3, 0, 0, 0, 2'd2, 1, 1, 1); desc_odd_i = desc_even_i;
    setup(48'h0, 2'd1, 2'd0, 5'd12, 1, 0); run("R5 relaxed lower");
    setup(48'h0, 2'd1, 2'd3, 5'd12, 1, 0); run("R5 relaxed higher");
    // R6: 32-bit mode ignores upper flags
    desc_even_i = mk(36'h4, 1, 1, 1, 2'd1, 0, 1, 1); desc_odd_i = desc_even_i;
    setup(48'h0, 2'd0, 2'd0, 5'd12, 0, 0); run("R6 fetch");
    setup(48'h0, 2'd1, 2'd0, 5'd12, 0, 0); run("R6 load");
    // R7: software bits cleared
    desc_even_i = mk(36'hF_FFFF_FFFF, 0, 0, 0, 2'd3, 1, 1, 1); desc_odd_i = desc_even_i;
    setup(48'h0000_0012_3456, 2'd2, 2'd0, 5'd21, 1, 0); run("R7 pa");
    // R9: hold while idle
    hold_res = result_o; hold_pa = paddr_o;
    setup(48'h0, 2'd0, 2'd0, 5'd5, 1, 1);
    @(negedge clk);
    chk(!rsp_valid_o && result_o == hold_res && paddr_o == hold_pa, "R9 hold",
        64'(result_o), 64'(hold_res));

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      desc_even_i = {$urandom, $urandom, $urandom};
      desc_odd_i  = {$urandom, $urandom, $urandom};
      setup({$urandom, $urandom}, 2'($urandom), 2'($urandom),
            5'($urandom_range(10, 31)), 1'($urandom), 1'($urandom));
      run("R4 R7 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule